// File: doc/BRIEF.md
# I/O Processor Fault Status Unit

This block sits beside an I/O processor and watches two kinds of reads: main-memory reads and reads of the processor's own subchannel store. It also watches two error strobes, one from the memory interface and one from the control memory. From these it builds a 32-bit status word. Each fault kind has a sticky flag in that word, and the upper field of the word holds the high-order bits of the address of the command doubleword being processed. The block also keeps a sticky processor fault indicator.

The block also decides how the current I/O operation ends. It uses the fault kind, whether the failing read was a command fetch or a data access, and the halt-on-transmission-error flag of the active command. From these it issues either a one-cycle "unusual end" terminate pulse or a one-cycle device halt request. A synchronous clear input wipes the sticky flags. Command execution and the channel datapath live elsewhere.

Top module: `iop_fault_status_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the status word, the fault indicator, the terminate pulse and the halt request are all zero, provided the address input is zero.
- R2: A main-memory read (`mem_rd_vld` high) whose two parity-error inputs differ sets status bit 1 (bus check). A read whose two parity inputs agree sets no status bit and does not set the fault indicator.
- R3: A bus check during a data access (`cmd_fetch` low) pulses `halt_req` for exactly one cycle if `halt_on_err` is high, and gives no pulse at all if it is low. A data access never pulses `term_pulse`.
- R4: A bus check during a command fetch (`cmd_fetch` high) pulses `term_pulse` for one cycle and does not pulse `halt_req`.
- R5: A subchannel read (`sub_rd_vld` high) with `sub_par_err` high sets status bit 2 (control check) and pulses `term_pulse` for one cycle.
- R6: `mif_err` sets status bit 3 (memory interface error). It ends the operation exactly as a bus check does: terminate on a command fetch, halt on a data access only if the halt flag is set.
- R7: `pfi` becomes 1 after any bus check, control check, memory interface error or control memory fault (`cmf_err`). A control memory fault alone sets no status bit.
- R8: Status bits 31:13 equal the value of `cmd_dw_addr` sampled at the previous clock edge.
- R9: Status bit 0 and bits 12:4 always read as zero.
- R10: Status bits 1 to 3 and `pfi` stay set until `flt_clr` is sampled high. `flt_clr` then clears them in the next cycle, unless a fault arrives in the same cycle, in which case that fault's bits stay set.
- R11: Results are due in the cycle after the fault is sampled. When several faults are sampled together, every matching status bit is set and exactly one single-cycle terminate pulse is issued if any of them calls for termination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_clr | input | 1 | Clears the sticky fault flags and the fault indicator |
| mem_rd_vld | input | 1 | A main-memory read completes this cycle |
| mem_side_pe | input | 1 | Parity-error status reported by the memory |
| iop_side_pe | input | 1 | Parity-error status seen by the I/O processor |
| cmd_fetch | input | 1 | 1: the read is a command fetch, 0: a data access |
| halt_on_err | input | 1 | Halt-on-transmission-error flag of the active command |
| sub_rd_vld | input | 1 | A subchannel read completes this cycle |
| sub_par_err | input | 1 | Parity error on that subchannel read |
| mif_err | input | 1 | Memory interface error strobe |
| cmf_err | input | 1 | Control memory fault strobe |
| cmd_dw_addr | input | 19 | High-order bits of the current command doubleword address |
| status | output | 32 | Fault status word |
| pfi | output | 1 | Sticky processor fault indicator |
| term_pulse | output | 1 | One-cycle unusual-end terminate request |
| halt_req | output | 1 | One-cycle device halt request |

## Verification
Every result of this block sits one register after its inputs: the status flags, the address field, the fault indicator and both end pulses. So a fault sampled at one rising edge shows up after that edge and no earlier. The bench drives each stimulus on a falling edge and removes it at the next falling edge. It reads the outputs at that same falling edge, which is half a cycle after the sampling edge. It reads the pulses again one falling edge later to confirm they are exactly one cycle wide and that the sticky flags have stayed set.

// File: rtl/iop_fault_pkg.sv
package iop_fault_pkg;

    localparam int STAT_W  = 32;
    localparam int CDA_W   = 19;
    localparam int CDA_LSB = STAT_W - CDA_W;
    localparam int BIT_BCF = 1;
    localparam int BIT_CCF = 2;
    localparam int BIT_MIE = 3;

    // Fault events detected in one cycle
    typedef struct packed {
        logic bcf;
        logic ccf;
        logic mie;
        logic cmf;
    } fault_evt_t;

    // Requested end of the current operation
    typedef struct packed {
        logic term;
        logic halt;
    } end_req_t;

    // Sticky status contents
    typedef struct packed {
        logic             bcf;
        logic             ccf;
        logic             mie;
        logic             pfi;
        logic [CDA_W-1:0] cda;
    } stat_state_t;

endpackage

// File: rtl/iop_fault_detect.sv
module iop_fault_detect
    import iop_fault_pkg::*;
(
    input  logic       mem_rd_vld,
    input  logic       mem_side_pe,
    input  logic       iop_side_pe,
    input  logic       cmd_fetch,
    input  logic       halt_on_err,
    input  logic       sub_rd_vld,
    input  logic       sub_par_err,
    input  logic       mif_err,
    input  logic       cmf_err,
    output fault_evt_t evt,
    output end_req_t   req
);

    logic mem_path_flt;

    always_comb begin
        // Disagreement between the two parity views is a bus check
        evt.bcf = mem_rd_vld & (mem_side_pe ^ iop_side_pe);
        evt.ccf = sub_rd_vld & sub_par_err;
        evt.mie = mif_err;
        evt.cmf = cmf_err;

        // Bus check and interface error share one ending policy
        mem_path_flt = evt.bcf | evt.mie;

        req.term = evt.ccf | (mem_path_flt & cmd_fetch);
        req.halt = mem_path_flt & ~cmd_fetch & halt_on_err;
    end

endmodule

// File: rtl/iop_fault_status.sv
module iop_fault_status
    import iop_fault_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_clr,
    input  fault_evt_t        evt,
    input  logic [CDA_W-1:0]  cda_in,
    output logic [STAT_W-1:0] status,
    output logic              pfi
);

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flt_clr) begin
            st_d.bcf = 1'b0;
            st_d.ccf = 1'b0;
            st_d.mie = 1'b0;
            st_d.pfi = 1'b0;
        end
        // New faults win over a clear in the same cycle
        st_d.bcf = st_d.bcf | evt.bcf;
        st_d.ccf = st_d.ccf | evt.ccf;
        st_d.mie = st_d.mie | evt.mie;
        st_d.pfi = st_d.pfi | evt.bcf | evt.ccf | evt.mie | evt.cmf;
        st_d.cda = cda_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status                          = '0;
        status[BIT_BCF]                 = st_q.bcf;
        status[BIT_CCF]                 = st_q.ccf;
        status[BIT_MIE]                 = st_q.mie;
        status[STAT_W-1:CDA_LSB]        = st_q.cda;
        pfi                             = st_q.pfi;
    end

endmodule

// File: rtl/iop_fault_action.sv
module iop_fault_action
    import iop_fault_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  end_req_t req,
    output logic     term_pulse,
    output logic     halt_req
);

    end_req_t act_d, act_q;

    always_comb begin
        // Pulses last one cycle: the next value depends only on this cycle
        act_d = req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else begin
            act_q <= act_d;
        end
    end

    assign term_pulse = act_q.term;
    assign halt_req   = act_q.halt;

endmodule

// File: rtl/iop_fault_status_unit.sv
module iop_fault_status_unit
    import iop_fault_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_clr,
    input  logic              mem_rd_vld,
    input  logic              mem_side_pe,
    input  logic              iop_side_pe,
    input  logic              cmd_fetch,
    input  logic              halt_on_err,
    input  logic              sub_rd_vld,
    input  logic              sub_par_err,
    input  logic              mif_err,
    input  logic              cmf_err,
    input  logic [CDA_W-1:0]  cmd_dw_addr,
    output logic [STAT_W-1:0] status,
    output logic              pfi,
    output logic              term_pulse,
    output logic              halt_req
);

    fault_evt_t evt;
    end_req_t   req;

    iop_fault_detect u_detect (
        .mem_rd_vld  (mem_rd_vld),
        .mem_side_pe (mem_side_pe),
        .iop_side_pe (iop_side_pe),
        .cmd_fetch   (cmd_fetch),
        .halt_on_err (halt_on_err),
        .sub_rd_vld  (sub_rd_vld),
        .sub_par_err (sub_par_err),
        .mif_err     (mif_err),
        .cmf_err     (cmf_err),
        .evt         (evt),
        .req         (req)
    );

    iop_fault_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .flt_clr (flt_clr),
        .evt     (evt),
        .cda_in  (cmd_dw_addr),
        .status  (status),
        .pfi     (pfi)
    );

    iop_fault_action u_action (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .term_pulse (term_pulse),
        .halt_req   (halt_req)
    );

endmodule

// File: rtl/iop_fault_status_unit_chk.sv
module iop_fault_status_unit_chk
    import iop_fault_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              flt_clr,
    input logic              mem_rd_vld,
    input logic              mem_side_pe,
    input logic              iop_side_pe,
    input logic              cmd_fetch,
    input logic              halt_on_err,
    input logic              sub_rd_vld,
    input logic              sub_par_err,
    input logic              mif_err,
    input logic              cmf_err,
    input logic [CDA_W-1:0]  cmd_dw_addr,
    input logic [STAT_W-1:0] status,
    input logic              pfi,
    input logic              term_pulse,
    input logic              halt_req
);

    logic bus_chk;
    logic any_flt;
    assign bus_chk = mem_rd_vld && (mem_side_pe != iop_side_pe);
    assign any_flt = bus_chk || (sub_rd_vld && sub_par_err) || mif_err || cmf_err;

    p_bcf_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_chk |=> status[1]);

    p_data_no_term_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_chk && !cmd_fetch && !mif_err && !(sub_rd_vld && sub_par_err)) |=> !term_pulse);

    p_fetch_term_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_chk && cmd_fetch) |=> (term_pulse && !halt_req));

    p_ccf_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_rd_vld && sub_par_err) |=> (status[2] && term_pulse));

    p_mie_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mif_err |=> status[3]);

    p_pfi_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any_flt |=> pfi);

    p_addr_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (status[STAT_W-1:CDA_LSB] == $past(cmd_dw_addr)));

    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] == 1'b0) && (status[12:4] == '0));

    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_clr && !any_flt) |=> (status[3:1] == 3'b000 && !pfi));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt_clr && pfi) |=> pfi);

endmodule

bind iop_fault_status_unit iop_fault_status_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flt_clr     (flt_clr),
    .mem_rd_vld  (mem_rd_vld),
    .mem_side_pe (mem_side_pe),
    .iop_side_pe (iop_side_pe),
    .cmd_fetch   (cmd_fetch),
    .halt_on_err (halt_on_err),
    .sub_rd_vld  (sub_rd_vld),
    .sub_par_err (sub_par_err),
    .mif_err     (mif_err),
    .cmf_err     (cmf_err),
    .cmd_dw_addr (cmd_dw_addr),
    .status      (status),
    .pfi         (pfi),
    .term_pulse  (term_pulse),
    .halt_req    (halt_req)
);

// File: tb/iop_fault_status_unit_tb.sv
module iop_fault_status_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flt_clr = 1'b0;
    logic        mem_rd_vld = 1'b0;
    logic        mem_side_pe = 1'b0;
    logic        iop_side_pe = 1'b0;
    logic        cmd_fetch = 1'b0;
    logic        halt_on_err = 1'b0;
    logic        sub_rd_vld = 1'b0;
    logic        sub_par_err = 1'b0;
    logic        mif_err = 1'b0;
    logic        cmf_err = 1'b0;
    logic [18:0] cmd_dw_addr = '0;
    logic [31:0] status;
    logic        pfi;
    logic        term_pulse;
    logic        halt_req;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    localparam logic [18:0] ADDR_A = 19'h5A5A5;

    always #5 clk = ~clk;

    iop_fault_status_unit u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .flt_clr     (flt_clr),
        .mem_rd_vld  (mem_rd_vld),
        .mem_side_pe (mem_side_pe),
        .iop_side_pe (iop_side_pe),
        .cmd_fetch   (cmd_fetch),
        .halt_on_err (halt_on_err),
        .sub_rd_vld  (sub_rd_vld),
        .sub_par_err (sub_par_err),
        .mif_err     (mif_err),
        .cmf_err     (cmf_err),
        .cmd_dw_addr (cmd_dw_addr),
        .status      (status),
        .pfi         (pfi),
        .term_pulse  (term_pulse),
        .halt_req    (halt_req)
    );

    function automatic logic [31:0] exp_stat(logic bcf, logic ccf, logic mie, logic [18:0] a);
        return {a, 9'b0, mie, ccf, bcf, 1'b0};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        flt_clr = 0; mem_rd_vld = 0; mem_side_pe = 0; iop_side_pe = 0;
        cmd_fetch = 0; halt_on_err = 0; sub_rd_vld = 0; sub_par_err = 0;
        mif_err = 0; cmf_err = 0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check_outs(string tag, logic [31:0] st, logic p, logic t, logic h);
        check({tag, " status"}, status, st);
        check({tag, " pfi"}, {31'b0, pfi}, {31'b0, p});
        check({tag, " term"}, {31'b0, term_pulse}, {31'b0, t});
        check({tag, " halt"}, {31'b0, halt_req}, {31'b0, h});
    endtask

    task automatic do_clear();
        flt_clr = 1; step(); idle();
        check_outs("R10 clear", exp_stat(0, 0, 0, ADDR_A), 0, 0, 0);
    endtask

    task automatic t_reset();
        check_outs("R1 in reset", 32'h0, 0, 0, 0);
        rst_n = 1; step();
        check_outs("R1 after reset", 32'h0, 0, 0, 0);
    endtask

    task automatic t_addr();
        cmd_dw_addr = 19'h7FFFF; step();
        check("R8 addr all ones", status, exp_stat(0, 0, 0, 19'h7FFFF));
        check("R9 reserved zero", status & 32'h00001FF1, 32'h0);
        cmd_dw_addr = ADDR_A; step();
        check("R8 addr pattern", status, exp_stat(0, 0, 0, ADDR_A));
    endtask

    task automatic t_bcf_agree();
        mem_rd_vld = 1; mem_side_pe = 1; iop_side_pe = 1; step(); idle();
        check_outs("R2 parity agree", exp_stat(0, 0, 0, ADDR_A), 0, 0, 0);
    endtask

    task automatic t_bcf_data_nohalt();
        mem_rd_vld = 1; mem_side_pe = 1; iop_side_pe = 0; step(); idle();
        check_outs("R3 data no halt flag", exp_stat(1, 0, 0, ADDR_A), 1, 0, 0);
        step();
        check_outs("R10 sticky bcf", exp_stat(1, 0, 0, ADDR_A), 1, 0, 0);
        do_clear();
    endtask

    task automatic t_bcf_data_halt();
        mem_rd_vld = 1; iop_side_pe = 1; halt_on_err = 1; step(); idle();
        check_outs("R3 data halt", exp_stat(1, 0, 0, ADDR_A), 1, 0, 1);
        step();
        check_outs("R3 halt one cycle", exp_stat(1, 0, 0, ADDR_A), 1, 0, 0);
        do_clear();
    endtask

    task automatic t_bcf_fetch();
        mem_rd_vld = 1; mem_side_pe = 1; cmd_fetch = 1; halt_on_err = 1; step(); idle();
        check_outs("R4 fetch term", exp_stat(1, 0, 0, ADDR_A), 1, 1, 0);
        step();
        check_outs("R4 term one cycle", exp_stat(1, 0, 0, ADDR_A), 1, 0, 0);
        do_clear();
    endtask

    task automatic t_ccf();
        sub_rd_vld = 1; sub_par_err = 0; step(); idle();
        check_outs("R5 clean subchannel read", exp_stat(0, 0, 0, ADDR_A), 0, 0, 0);
        sub_rd_vld = 1; sub_par_err = 1; step(); idle();
        check_outs("R5 control check", exp_stat(0, 1, 0, ADDR_A), 1, 1, 0);
        do_clear();
    endtask

    task automatic t_mie();
        mif_err = 1; halt_on_err = 1; step(); idle();
        check_outs("R6 mie data halt", exp_stat(0, 0, 1, ADDR_A), 1, 0, 1);
        mif_err = 1; cmd_fetch = 1; step(); idle();
        check_outs("R6 mie fetch term", exp_stat(0, 0, 1, ADDR_A), 1, 1, 0);
        mif_err = 1; step(); idle();
        check_outs("R6 mie data no flag", exp_stat(0, 0, 1, ADDR_A), 1, 0, 0);
        do_clear();
    endtask

    task automatic t_cmf();
        cmf_err = 1; step(); idle();
        check_outs("R7 control memory fault", exp_stat(0, 0, 0, ADDR_A), 1, 0, 0);
        step();
        check_outs("R7 pfi sticky", exp_stat(0, 0, 0, ADDR_A), 1, 0, 0);
        do_clear();
    endtask

    task automatic t_multi();
        mem_rd_vld = 1; mem_side_pe = 1; cmd_fetch = 1;
        sub_rd_vld = 1; sub_par_err = 1; mif_err = 1; step(); idle();
        check_outs("R11 all faults", exp_stat(1, 1, 1, ADDR_A), 1, 1, 0);
        step();
        check_outs("R11 single term", exp_stat(1, 1, 1, ADDR_A), 1, 0, 0);
        do_clear();
    endtask

    task automatic t_clr_collide();
        sub_rd_vld = 1; sub_par_err = 1; step(); idle();
        flt_clr = 1; mem_rd_vld = 1; iop_side_pe = 1; step(); idle();
        check_outs("R10 fault beats clear", exp_stat(1, 0, 0, ADDR_A), 1, 0, 0);
        do_clear();
    endtask

    initial begin
        idle();
        step(); step();
        t_reset();
        t_addr();
        t_bcf_agree();
        t_bcf_data_nohalt();
        t_bcf_data_halt();
        t_bcf_fetch();
        t_ccf();
        t_mie();
        t_cmf();
        t_multi();
        t_clr_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule